// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Sequencer

This block is the control path of a small processor with byte-addressed memory. It owns four registers: the program counter, the instruction register, the memory address register and the memory data register. It repeats one cycle without end. It fetches a word, decodes it, fetches an operand, executes, stores the result and then fetches again. Each memory access, whether for an instruction or for data, passes through the address/data register pair. The memory is a single-port device. It has separate read and write strobes and a ready handshake.

The register file and the ALU are in a separate datapath. The sequencer drives that datapath through register selects, an ALU go strobe with a function code, and a write-back strobe. The write-back strobe carries a destination index and a flag that chooses between the ALU result and the loaded word. Words are `DATA_W/8` bytes wide, so the program counter steps by 4 with the default parameters. A halt instruction freezes the sequencer until reset. Any undefined opcode also freezes it.

Top module: `fetch_exec_seq`

## Requirements
- R1: While `rst_n` is low, `mem_rd`, `mem_wr`, `dp_alu_go`, `dp_wb_en` and `halted` are all 0. The first memory command after reset is a read at byte address 0.
- R2: Every fetch issues a read at the current program counter. The word returned with ready becomes the next instruction. The instruction fields are: opcode in bits [31:28], rd in bits [27:24], rs in bits [23:20], rt in bits [19:16] and the immediate in bits [15:0].
- R3: A read or write command stays asserted, with `mem_addr` and `mem_wdata` unchanged, until the cycle in which `mem_ready` is 1. Read data is taken in that cycle. `mem_rd` and `mem_wr` are never 1 at the same time.
- R4: The program counter grows by 4 (one word) in the cycle a fetch completes, which is before execute. When no jump occurs, successive fetch addresses differ by 4.
- R5: Opcode 1 (ALU) does three things. It sets `dp_rsel_a`=rs and `dp_rsel_b`=rt. It pulses `dp_alu_go` for one cycle with `dp_alu_fn` equal to immediate bits [3:0]. In the next cycle it pulses `dp_wb_en` with `dp_wb_idx`=rd and `dp_wb_mem`=0.
- R6: Opcode 2 (load) reads at the effective address. The effective address is the rs value plus the zero-extended immediate, modulo 2^ADDR_W. The sequencer then pulses `dp_wb_en` with `dp_wb_idx`=rd, `dp_wb_mem`=1 and `dp_wb_data` equal to the word read.
- R7: Opcode 3 (store) writes the rt value to the effective address defined in R6.
- R8: Opcode 4 (jump) makes the next fetch read at a computed address. That address is the already-advanced program counter plus four times the sign-extended immediate, modulo 2^ADDR_W. This works for both forward and backward offsets.
- R9: Opcode 0 (halt) raises `halted`, which then stays 1. After that no memory command, ALU strobe or write-back strobe occurs until reset.
- R10: Opcodes 5 through 15 behave exactly like opcode 0.
- R11: At most one of `mem_rd`, `mem_wr`, `dp_alu_go` and `dp_wb_en` is 1 in any cycle. Every instruction that does not halt is followed by a fetch, in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Memory byte address (address register) |
| mem_wdata | output | DATA_W | Memory write data (data register) |
| mem_rd | output | 1 | Read command, held until ready |
| mem_wr | output | 1 | Write command, held until ready |
| mem_rdata | input | DATA_W | Read data, valid with ready |
| mem_ready | input | 1 | Memory completes the pending command |
| dp_rsel_a | output | 4 | Register select for operand A (rs) |
| dp_rsel_b | output | 4 | Register select for operand B (rt) |
| dp_a_val | input | DATA_W | Value of the register picked by `dp_rsel_a` |
| dp_b_val | input | DATA_W | Value of the register picked by `dp_rsel_b` |
| dp_alu_go | output | 1 | One-cycle ALU execute strobe |
| dp_alu_fn | output | 4 | ALU function code |
| dp_wb_en | output | 1 | Register write-back strobe |
| dp_wb_idx | output | 4 | Write-back destination register |
| dp_wb_mem | output | 1 | 1: write back loaded word, 0: ALU result |
| dp_wb_data | output | DATA_W | Loaded word for write-back |
| halted | output | 1 | Sequencer is stopped |

## Verification
The checks assume the datapath returns register values that do not change while an instruction is in flight. They also assume the memory raises ready only while a command is pending and does so within a bounded number of cycles. The bench's memory model meets both assumptions. It grants each command after a random wait of 0 to 3 cycles and drops ready as soon as no command is up. The register values stay fixed for each program. Random load and store offsets are kept small and base values are kept in a high window, so every data address falls outside the program area and no store can change the code being run.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int OPC_W  = 4;
  localparam int RIDX_W = 4;
  localparam int IMM_W  = 16;
  localparam int FN_W   = 4;

  localparam logic [OPC_W-1:0] OPC_HALT  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_ALU   = 4'h1;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h3;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 4'h4;

  typedef enum logic [2:0] {
    K_ALU, K_LOAD, K_STORE, K_JUMP, K_STOP
  } kind_e;

  typedef enum logic [3:0] {
    S_IF_ADDR, S_IF_RD, S_IF_IR, S_DECODE, S_OPF,
    S_MRD, S_MWR, S_EXEC, S_WB, S_HALT
  } state_e;

  typedef struct packed {
    kind_e             kind;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rt;
    logic [IMM_W-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/fes_decode.sv
module fes_decode import fes_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] ir,
  output dec_t              dec
);
  localparam int OP_LSB = DATA_W - OPC_W;
  localparam int RD_LSB = OP_LSB - RIDX_W;
  localparam int RS_LSB = RD_LSB - RIDX_W;
  localparam int RT_LSB = RS_LSB - RIDX_W;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc     = ir[OP_LSB +: OPC_W];
    dec.rd  = ir[RD_LSB +: RIDX_W];
    dec.rs  = ir[RS_LSB +: RIDX_W];
    dec.rt  = ir[RT_LSB +: RIDX_W];
    dec.imm = ir[IMM_W-1:0];
    case (opc)
      OPC_ALU:   dec.kind = K_ALU;
      OPC_LOAD:  dec.kind = K_LOAD;
      OPC_STORE: dec.kind = K_STORE;
      OPC_JUMP:  dec.kind = K_JUMP;
      default:   dec.kind = K_STOP;   // halt and every undefined code
    endcase
  end
endmodule

// File: rtl/fes_addr_gen.sv
module fes_addr_gen import fes_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] pc_inc,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] jmp_tgt
);
  localparam int STEP = DATA_W / 8;

  function automatic logic [ADDR_W-1:0] f_inc(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(STEP);
  endfunction

  function automatic logic [ADDR_W-1:0] f_ea(input logic [DATA_W-1:0] b,
                                             input logic [IMM_W-1:0] i);
    return ADDR_W'(b + DATA_W'(i));
  endfunction

  function automatic logic [ADDR_W-1:0] f_tgt(input logic [ADDR_W-1:0] p,
                                              input logic [IMM_W-1:0] i);
    return p + ADDR_W'($signed(i)) * ADDR_W'(STEP);
  endfunction

  assign pc_inc  = f_inc(pc);
  assign ea      = f_ea(base, imm);
  assign jmp_tgt = f_tgt(pc, imm);
endmodule

// File: rtl/fes_ctrl_fsm.sv
module fes_ctrl_fsm import fes_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  kind_e  kind,
  input  logic   mem_ready,
  output state_e state
);
  state_e nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IF_ADDR;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IF_ADDR: nxt = S_IF_RD;
      S_IF_RD:   if (mem_ready) nxt = S_IF_IR;
      S_IF_IR:   nxt = S_DECODE;
      S_DECODE: begin
        case (kind)
          K_ALU, K_JUMP:    nxt = S_EXEC;
          K_LOAD, K_STORE:  nxt = S_OPF;
          default:          nxt = S_HALT;
        endcase
      end
      S_OPF:     nxt = (kind == K_LOAD) ? S_MRD : S_MWR;
      S_MRD:     if (mem_ready) nxt = S_WB;
      S_MWR:     if (mem_ready) nxt = S_IF_ADDR;
      S_EXEC:    nxt = (kind == K_ALU) ? S_WB : S_IF_ADDR;
      S_WB:      nxt = S_IF_ADDR;
      S_HALT:    nxt = S_HALT;
      default:   nxt = S_HALT;
    endcase
  end
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq import fes_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [RIDX_W-1:0] dp_rsel_a,
  output logic [RIDX_W-1:0] dp_rsel_b,
  input  logic [DATA_W-1:0] dp_a_val,
  input  logic [DATA_W-1:0] dp_b_val,
  output logic              dp_alu_go,
  output logic [FN_W-1:0]   dp_alu_fn,
  output logic              dp_wb_en,
  output logic [RIDX_W-1:0] dp_wb_idx,
  output logic              dp_wb_mem,
  output logic [DATA_W-1:0] dp_wb_data,
  output logic              halted
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, mdr_q;
  logic [ADDR_W-1:0] pc_inc, ea, jmp_tgt;
  dec_t              dec;
  state_e            state;

  // named events for the checker
  logic ev_fetch_done;
  logic ev_data_rd_done;

  fes_decode #(.DATA_W(DATA_W)) u_dec (
    .ir  (ir_q),
    .dec (dec)
  );

  fes_addr_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agen (
    .pc      (pc_q),
    .base    (dp_a_val),
    .imm     (dec.imm),
    .pc_inc  (pc_inc),
    .ea      (ea),
    .jmp_tgt (jmp_tgt)
  );

  fes_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (dec.kind),
    .mem_ready (mem_ready),
    .state     (state)
  );

  assign ev_fetch_done   = (state == S_IF_RD) && mem_ready;
  assign ev_data_rd_done = (state == S_MRD) && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
    end else begin
      case (state)
        S_IF_ADDR: mar_q <= pc_q;
        S_IF_RD: if (ev_fetch_done) begin
          mdr_q <= mem_rdata;
          pc_q  <= pc_inc;
        end
        S_IF_IR: ir_q <= mdr_q;
        S_OPF: begin
          mar_q <= ea;
          if (dec.kind == K_STORE) mdr_q <= dp_b_val;
        end
        S_MRD: if (ev_data_rd_done) mdr_q <= mem_rdata;
        S_EXEC: if (dec.kind == K_JUMP) pc_q <= jmp_tgt;
        default: ;
      endcase
    end
  end

  assign mem_addr   = mar_q;
  assign mem_wdata  = mdr_q;
  assign mem_rd     = (state == S_IF_RD) || (state == S_MRD);
  assign mem_wr     = (state == S_MWR);
  assign dp_rsel_a  = dec.rs;
  assign dp_rsel_b  = dec.rt;
  assign dp_alu_go  = (state == S_EXEC) && (dec.kind == K_ALU);
  assign dp_alu_fn  = dec.imm[FN_W-1:0];
  assign dp_wb_en   = (state == S_WB);
  assign dp_wb_idx  = dec.rd;
  assign dp_wb_mem  = (dec.kind == K_LOAD);
  assign dp_wb_data = mdr_q;
  assign halted     = (state == S_HALT);
endmodule

// File: rtl/fetch_exec_seq_chk.sv
module fetch_exec_seq_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              halted,
  input logic              ev_fetch_done,
  input logic [ADDR_W-1:0] pc_q,
  input logic              dp_alu_go,
  input logic              dp_wb_en
);
  localparam int STEP = DATA_W / 8;

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R3

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ready |=>
      (mem_rd == $past(mem_rd)) && (mem_wr == $past(mem_wr)) &&
      $stable(mem_addr) && $stable(mem_wdata)); // R3

  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_done |-> mem_rd && (mem_addr == pc_q)); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_done |=> pc_q == ADDR_W'($past(pc_q) + ADDR_W'(STEP))); // R4

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R9

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_rd && !mem_wr && !dp_alu_go && !dp_wb_en); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr, dp_alu_go, dp_wb_en}) <= 1); // R11
endmodule

bind fetch_exec_seq fetch_exec_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .mem_ready     (mem_ready),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .halted        (halted),
  .ev_fetch_done (ev_fetch_done),
  .pc_q          (pc_q),
  .dp_alu_go     (dp_alu_go),
  .dp_wb_en      (dp_wb_en)
);

// File: tb/sim_fetch_exec_seq.sv
module sim_fetch_exec_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int PROG_WORDS = 64;
  localparam logic [2:0] K_RD = 3'd1, K_WR = 3'd2, K_ALU = 3'd3, K_WB = 3'd4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] a;
    logic [31:0] d;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata = '0, dp_a_val, dp_b_val, dp_wb_data;
  logic mem_rd, mem_wr, mem_ready = 0, dp_alu_go, dp_wb_en, dp_wb_mem, halted;
  logic [3:0] dp_rsel_a, dp_rsel_b, dp_alu_fn, dp_wb_idx;

  logic [31:0] prog [PROG_WORDS];
  logic [31:0] regs [16];
  ev_t expq [$];
  int checks = 0, fails = 0;
  logic [3:0] last_op;

  assign dp_a_val = regs[dp_rsel_a];
  assign dp_b_val = regs[dp_rsel_b];

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_exec_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .dp_rsel_a(dp_rsel_a), .dp_rsel_b(dp_rsel_b), .dp_a_val(dp_a_val), .dp_b_val(dp_b_val),
    .dp_alu_go(dp_alu_go), .dp_alu_fn(dp_alu_fn), .dp_wb_en(dp_wb_en), .dp_wb_idx(dp_wb_idx),
    .dp_wb_mem(dp_wb_mem), .dp_wb_data(dp_wb_data), .halted(halted));

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                      input logic [3:0] rs, input logic [3:0] rt,
                                      input logic [15:0] imm);
    return {op, rd, rs, rt, imm};
  endfunction

  function automatic logic [31:0] data_fn(input logic [15:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    if (a < 16'(PROG_WORDS * 4)) return prog[int'(a >> 2)];
    return data_fn(a);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent instruction-level model: builds the expected event stream
  task automatic build_expected();
    logic [15:0] pc = 16'h0;
    expq.delete();
    last_op = 4'h0;
    for (int s = 0; s < 256; s++) begin
      logic [31:0] w = mem_word(pc);
      logic [15:0] eadr;
      logic [3:0]  op = w[31:28];
      expq.push_back('{K_RD, pc, w});          // R2 fetch at PC
      pc = pc + 16'd4;                         // R4
      eadr = regs[w[23:20]][15:0] + w[15:0];
      if (op == 4'h1) begin                    // R5
        expq.push_back('{K_ALU, {w[23:20], w[19:16], w[3:0], 4'h0}, 32'h0});
        expq.push_back('{K_WB, {w[27:24], 11'h0, 1'b0}, 32'h0});
      end else if (op == 4'h2) begin           // R6
        expq.push_back('{K_RD, eadr, mem_word(eadr)});
        expq.push_back('{K_WB, {w[27:24], 11'h0, 1'b1}, mem_word(eadr)});
      end else if (op == 4'h3) begin           // R7
        expq.push_back('{K_WR, eadr, regs[w[19:16]]});
      end else if (op == 4'h4) begin           // R8
        pc = pc + {w[13:0], 2'b00};
      end else begin                           // R9, R10
        last_op = op;
        break;
      end
    end
  endtask

  task automatic got(input ev_t e);
    string req;
    ev_t x;
    case (e.kind)
      K_RD:    req = "R2/R6/R8";
      K_WR:    req = "R7";
      K_ALU:   req = "R5";
      default: req = "R5/R6";
    endcase
    if (expq.size() == 0) begin
      check(0, "R11", "unexpected event", {13'h0, e}, 64'h0);
    end else begin
      x = expq.pop_front();
      check(e == x, req, "event", {13'h0, e}, {13'h0, x});
    end
  endtask

  // memory model + monitor, all at the falling edge
  bit busy = 0, wait_prev = 0, prev_rd = 0;
  int lat = 0;
  logic [15:0] prev_addr;
  logic [31:0] prev_wdata;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 0; busy = 0; wait_prev = 0;
    end else begin
      if (wait_prev)
        check((mem_rd | mem_wr) && mem_rd == prev_rd && mem_addr == prev_addr &&
              mem_wdata == prev_wdata, "R3", "command held",
              {mem_rd, mem_wr, mem_addr, mem_wdata}, {prev_rd, ~prev_rd, prev_addr, prev_wdata});
      if (dp_alu_go) got('{K_ALU, {dp_rsel_a, dp_rsel_b, dp_alu_fn, 4'h0}, 32'h0});
      if (dp_wb_en)  got('{K_WB, {dp_wb_idx, 11'h0, dp_wb_mem}, dp_wb_mem ? dp_wb_data : 32'h0});
      if (!(mem_rd | mem_wr)) begin
        mem_ready = 0; busy = 0; wait_prev = 0;
      end else begin
        if (!busy) begin busy = 1; lat = int'($urandom % 4); end
        if (lat == 0) begin
          mem_ready = 1; busy = 0; wait_prev = 0;
          if (mem_rd) begin
            mem_rdata = mem_word(mem_addr);
            got('{K_RD, mem_addr, mem_rdata});
          end else got('{K_WR, mem_addr, mem_wdata});
        end else begin
          mem_ready = 0; lat--; wait_prev = 1;
          prev_addr = mem_addr; prev_rd = mem_rd; prev_wdata = mem_wdata;
        end
      end
    end
  end

  task automatic run_prog(input string name);
    build_expected();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!mem_rd && !mem_wr && !dp_alu_go && !dp_wb_en && !halted, "R1", "reset state",
          {59'h0, mem_rd, mem_wr, dp_alu_go, dp_wb_en, halted}, 64'h0);
    rst_n = 1;
    for (int c = 0; c < 4000 && !halted; c++) @(negedge clk);
    repeat (12) @(negedge clk);
    check(halted == 1'b1, (last_op == 4'h0) ? "R9" : "R10", {name, " halted"},
          {63'h0, halted}, 64'h1);
    check(!mem_rd && !mem_wr, "R9", {name, " quiet after halt"},
          {62'h0, mem_rd, mem_wr}, 64'h0);
    check(expq.size() == 0, "R11", {name, " all events seen"},
          64'(expq.size()), 64'h0);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < PROG_WORDS; i++) prog[i] = enc(4'h0, 4'h0, 4'h0, 4'h0, 16'h0);
    for (int i = 0; i < 16; i++) regs[i] = {16'hC0DE, 16'h1000 + 16'(i * 16'h0100)};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // directed: ALU, load, store, forward jump, halt
    clear_prog();
    prog[0] = enc(4'h1, 4'h3, 4'h1, 4'h2, 16'h0005);
    prog[1] = enc(4'h2, 4'h4, 4'h1, 4'h0, 16'h0010);
    prog[2] = enc(4'h3, 4'h0, 4'h5, 4'h2, 16'h0204);
    prog[3] = enc(4'h4, 4'h0, 4'h0, 4'h0, 16'h0001);
    prog[4] = enc(4'h1, 4'h7, 4'h7, 4'h7, 16'h000F);
    prog[5] = enc(4'h0, 4'h0, 4'h0, 4'h0, 16'h0000);
    run_prog("directed");
    // backward jump (R8): 0 -> 2 -> 1 (halt)
    clear_prog();
    prog[0] = enc(4'h4, 4'h0, 4'h0, 4'h0, 16'h0001);
    prog[1] = enc(4'h0, 4'h0, 4'h0, 4'h0, 16'h0000);
    prog[2] = enc(4'h4, 4'h0, 4'h0, 4'h0, 16'hFFFE);
    run_prog("backward jump");
    // address wrap on load (R6) then undefined opcode (R10)
    clear_prog();
    regs[6] = 32'hABCD_F000;
    prog[0] = enc(4'h2, 4'h9, 4'h6, 4'h0, 16'h2000);
    prog[1] = enc(4'hF, 4'h0, 4'h0, 4'h0, 16'h0000);
    run_prog("wrap+undefined");
    // constrained random programs
    for (int t = 0; t < 20; t++) begin
      int len = 8 + int'($urandom % 40);
      clear_prog();
      for (int i = 0; i < 16; i++)
        regs[i] = {16'($urandom), 16'h1000 + 16'($urandom % 32'h6000)};
      for (int i = 0; i < len - 1; i++) begin
        logic [3:0] op = 4'(1 + $urandom % 4);
        logic [15:0] imm;
        if (op == 4'h4) imm = 16'($urandom % (len - 1 - i));
        else if (op == 4'h1) imm = 16'($urandom);
        else imm = 16'($urandom % 32'h1000);
        prog[i] = enc(op, 4'($urandom), 4'($urandom), 4'($urandom), imm);
      end
      begin
        int pick = int'($urandom % 12);
        prog[len - 1] = enc((pick == 0) ? 4'h0 : 4'(pick + 4), 4'h0, 4'h0, 4'h0, 16'h0);
      end
      run_prog("random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule